// File: doc/BRIEF.md
# Sensor Matrix Scanner with Change-Locked Image RAM

This block drives the rows of an 8x8 switch or sensor matrix one at a time and keeps an unencoded copy of every row's return-line levels in a small row-addressed image RAM. Each row is driven for a fixed number of clock cycles. On the last cycle of that window the return lines are compared with the stored copy of the row. If they differ, the new levels are written and an interrupt request is raised.

While the interrupt request is high the image is frozen. The host sees the first change and not a blur of later ones. The host clears the lock with an end-interrupt command, or with a clear command that also rewinds the read pointer. The host reads rows through a pointer that it loads with a command. It can ask for the pointer to step after every read, wrapping from the last row to row 0.

Top module: `sensor_matrix_ctl`

## Requirements
- R1: After reset `row_sel_o` is 8'b0000_0001. It stays one-hot, and each row is held for DWELL cycles. The scan moves to the next higher row and wraps from the last row to row 0.
- R2: After reset `irq_o` is 0, every image row reads 0, the read pointer is 0 and auto-increment is off.
- R3: On the last cycle of a row's window, if `ret_i` differs from the stored row and the image is unlocked, the row is written with `ret_i`. `irq_o` is 1 from the next cycle.
- R4: If `ret_i` equals the stored row, nothing is written and `irq_o` does not rise.
- R5: While `irq_o` is 1, no image row changes, whatever the return lines do.
- R6: The end-interrupt command has bits [7:5] = 3'b111. It lowers `irq_o` and unlocks the image.
- R7: The read-setup command has bits [7:5] = 3'b010, auto-increment flag in bit 4 and start row in bits [3:0]. After it, a one-cycle `rd_i` pulse puts the addressed row on `rd_data_o` in the next cycle.
- R8: With auto-increment on, the pointer advances after each read and wraps from row 7 to row 0. With it off, the pointer holds.
- R9: The clear command has bits [7:5] = 3'b110. When bit 1 or bit 0 is set, it lowers `irq_o`, unlocks the image and sets the pointer to row 0, keeping the auto-increment flag. When both bits are 0 it has no effect.
- R10: If an acknowledge (R6 or R9) and a detected change fall in the same cycle, the row is written and `irq_o` stays 1.
- R11: Commands with any other bits [7:5], and read-setup commands whose row field is 8 or more, change neither the pointer nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_i | input | 8 | Return-line levels of the driven row |
| row_sel_o | output | 8 | One-hot row drive |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_data_i | input | 8 | Command byte |
| rd_i | input | 1 | Image read strobe |
| rd_data_o | output | 8 | Row read from the image |
| irq_o | output | 1 | Change interrupt request / image lock |

## Verification
Every row in turn is given a fresh pattern and then its complement. After each change the whole image is read back, which shows that only the scanned row moved and that the interrupt follows. A test with two rows changing at once separates a frozen image from one that keeps updating: exactly one row may move before the acknowledge. An acknowledge placed exactly on a row's sampling cycle separates the intended priority of a change from an acknowledge that wins. Pointer tests cover wrap-around, a pointer held with auto-increment off, the clear rewind, and ignored command codes.

// File: rtl/smx_pkg.sv
package smx_pkg;
  typedef enum logic [2:0] {
    OP_RDSET = 3'b010,
    OP_CLEAR = 3'b110,
    OP_EOI   = 3'b111
  } smx_op_e;

  localparam int CMD_W    = 8;
  localparam int AI_BIT   = 4;
  localparam int ROWF_W   = 4;
  localparam int CF_BIT   = 1;
  localparam int CA_BIT   = 0;
endpackage

// File: rtl/smx_scan_seq.sv
module smx_scan_seq #(
  parameter int ROWS  = 8,
  parameter int DWELL = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int DW = (DWELL > 1) ? $clog2(DWELL) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [RW-1:0]   row_idx_o,
  output logic [ROWS-1:0] row_sel_o,
  output logic            sample_o
);
  logic [DW-1:0] cnt_q;
  logic [RW-1:0] row_q;
  logic [ROWS-1:0] sel_q;

  assign sample_o  = (cnt_q == DW'(DWELL - 1));
  assign row_idx_o = row_q;
  assign row_sel_o = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      row_q <= '0;
      sel_q <= ROWS'(1);
    end else if (sample_o) begin
      cnt_q <= '0;
      row_q <= (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
      if (ROWS > 1) sel_q <= {sel_q[ROWS-2:0], sel_q[ROWS-1]};
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(row_sel_o) == 1);
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_o |=> $stable(row_sel_o));
endmodule

// File: rtl/smx_image_ram.sv
module smx_image_ram #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample_i,
  input  logic [RW-1:0]   scan_row_i,
  input  logic [COLS-1:0] ret_i,
  input  logic            ack_i,
  input  logic [RW-1:0]   rd_addr_i,
  output logic [COLS-1:0] rd_row_o,
  output logic            irq_o
);
  logic [COLS-1:0] img_q [ROWS];
  logic            irq_q;
  logic            differ;
  logic            unlocked;
  logic            wr_en;
  logic [ROWS*COLS-1:0] img_flat;

  assign differ   = (ret_i != img_q[scan_row_i]);
  assign unlocked = !irq_q || ack_i;
  assign wr_en    = sample_i && differ && unlocked;
  assign rd_row_o = img_q[rd_addr_i];
  assign irq_o    = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROWS; i++) img_q[i] <= '0;
    end else if (wr_en) begin
      img_q[scan_row_i] <= ret_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (wr_en) irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  always_comb begin
    for (int i = 0; i < ROWS; i++) img_flat[i*COLS +: COLS] = img_q[i];
  end

  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    irq_q && !ack_i |=> $stable(img_flat));
  a_r4_equal_no_write: assert property (@(posedge clk) disable iff (rst)
    sample_i && !differ |=> $stable(img_flat));
  a_r6_ack_drops: assert property (@(posedge clk) disable iff (rst)
    ack_i && !(sample_i && differ) |=> !irq_q);
  a_r10_change_wins: assert property (@(posedge clk) disable iff (rst)
    sample_i && differ && ack_i |=> irq_q);
endmodule

// File: rtl/smx_host_port.sv
module smx_host_port
  import smx_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  input  logic             rd_i,
  input  logic [COLS-1:0]  rd_row_i,
  output logic [RW-1:0]    ptr_o,
  output logic [COLS-1:0]  rd_data_o,
  output logic             ack_o
);
  logic [RW-1:0]     ptr_q;
  logic              ai_q;
  logic [COLS-1:0]   rd_q;
  logic [2:0]        op;
  logic [ROWF_W-1:0] row_field;
  logic              set_hit;
  logic              clear_hit;

  assign op        = cmd_data_i[CMD_W-1 -: 3];
  assign row_field = cmd_data_i[ROWF_W-1:0];
  assign set_hit   = cmd_we_i && (op == OP_RDSET) && (row_field < ROWF_W'(ROWS));
  assign clear_hit = cmd_we_i && (op == OP_CLEAR) &&
                     (cmd_data_i[CF_BIT] || cmd_data_i[CA_BIT]);
  assign ack_o     = clear_hit || (cmd_we_i && (op == OP_EOI));
  assign ptr_o     = ptr_q;
  assign rd_data_o = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      ai_q  <= 1'b0;
    end else if (set_hit) begin
      ptr_q <= row_field[RW-1:0];
      ai_q  <= cmd_data_i[AI_BIT];
    end else if (clear_hit) begin
      ptr_q <= '0;
    end else if (rd_i && ai_q) begin
      ptr_q <= (ptr_q == RW'(ROWS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rd_q <= '0;
    else if (rd_i) rd_q <= rd_row_i;
  end

  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    rd_i && !cmd_we_i && ai_q && ptr_q == RW'(ROWS - 1) |=> ptr_q == '0);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    rd_i && !cmd_we_i && !ai_q |=> $stable(ptr_q));
  a_r9_rewind: assert property (@(posedge clk) disable iff (rst)
    clear_hit |=> ptr_q == '0);
  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !set_hit && !clear_hit && !rd_i |=> $stable(ptr_q));
endmodule

// File: rtl/sensor_matrix_ctl.sv
module sensor_matrix_ctl
  import smx_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DWELL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COLS-1:0]  ret_i,
  output logic [ROWS-1:0]  row_sel_o,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  input  logic             rd_i,
  output logic [COLS-1:0]  rd_data_o,
  output logic             irq_o
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [RW-1:0]   scan_row;
  logic            sample;
  logic [RW-1:0]   ptr;
  logic [COLS-1:0] rd_row;
  logic            ack;

  initial begin
    a_cfg_rows: assert (ROWS <= (1 << ROWF_W));
  end

  smx_scan_seq #(.ROWS(ROWS), .DWELL(DWELL)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .row_idx_o (scan_row),
    .row_sel_o (row_sel_o),
    .sample_o  (sample)
  );

  smx_image_ram #(.ROWS(ROWS), .COLS(COLS)) u_img (
    .clk        (clk),
    .rst        (rst),
    .sample_i   (sample),
    .scan_row_i (scan_row),
    .ret_i      (ret_i),
    .ack_i      (ack),
    .rd_addr_i  (ptr),
    .rd_row_o   (rd_row),
    .irq_o      (irq_o)
  );

  smx_host_port #(.ROWS(ROWS), .COLS(COLS)) u_host (
    .clk        (clk),
    .rst        (rst),
    .cmd_we_i   (cmd_we_i),
    .cmd_data_i (cmd_data_i),
    .rd_i       (rd_i),
    .rd_row_i   (rd_row),
    .ptr_o      (ptr),
    .rd_data_o  (rd_data_o),
    .ack_o      (ack)
  );
endmodule

// File: tb/sensor_matrix_ctl_tb_top.sv
module sensor_matrix_ctl_tb_top;
  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int DWELL = 4;
  localparam int SCAN  = ROWS * DWELL;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [COLS-1:0] ret;
  logic [ROWS-1:0] row_sel;
  logic            cmd_we = 1'b0;
  logic [7:0]      cmd_data = '0;
  logic            rd = 1'b0;
  logic [COLS-1:0] rd_data;
  logic            irq;

  logic [COLS-1:0] mtx [ROWS];
  logic [COLS-1:0] exp_img [ROWS];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb begin
    ret = '0;
    for (int i = 0; i < ROWS; i++) if (row_sel[i]) ret = mtx[i];
  end

  sensor_matrix_ctl #(.ROWS(ROWS), .COLS(COLS), .DWELL(DWELL)) dut_i (
    .clk(clk), .rst(rst), .ret_i(ret), .row_sel_o(row_sel),
    .cmd_we_i(cmd_we), .cmd_data_i(cmd_data), .rd_i(rd),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_data = c;
    @(negedge clk); cmd_we = 1'b0; cmd_data = '0;
  endtask

  task automatic rd_row(output logic [COLS-1:0] v);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rd_data;
  endtask

  task automatic check_image(input string tag);
    logic [COLS-1:0] v;
    cmd(8'h50);
    for (int i = 0; i < ROWS; i++) begin
      rd_row(v);
      chk(tag, v, exp_img[i]);
    end
  endtask

  task automatic wait_scan();
    repeat (SCAN + 4) @(negedge clk);
  endtask

  initial begin
    logic [COLS-1:0] v;
    logic [COLS-1:0] pat;
    int moved;
    for (int i = 0; i < ROWS; i++) begin mtx[i] = '0; exp_img[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: scan order and dwell, counted from reset release
    for (int n = 0; n < 2 * SCAN; n++) begin
      chk("R1 scan", row_sel, ROWS'(1) << ((n / DWELL) % ROWS));
      @(negedge clk);
    end
    // R2: reset state
    chk("R2 irq", irq, 0);
    begin
      logic [COLS-1:0] r0;
      rd_row(r0);
      chk("R2 ptr0", r0, 0);
    end
    check_image("R2 image");
    // R3/R6: each row, pattern then complement
    for (int pass = 0; pass < 2; pass++) begin
      for (int r = 0; r < ROWS; r++) begin
        pat = COLS'(8'hA5 ^ (r * 8'h11));
        if (pass == 1) pat = ~pat;
        mtx[r] = pat; exp_img[r] = pat;
        wait_scan();
        chk("R3 irq", irq, 1);
        check_image("R3 image");
        cmd(8'hE0);
        chk("R6 eoi", irq, 0);
      end
    end
    // R4: unchanged returns
    repeat (3) wait_scan();
    chk("R4 irq", irq, 0);
    check_image("R4 image");
    // R5: two rows change, only one may land before acknowledge
    mtx[2] = 8'h3C; mtx[5] = 8'hC3;
    wait_scan();
    chk("R5 irq", irq, 1);
    wait_scan();
    moved = 0;
    cmd(8'h42); rd_row(v); if (v == 8'h3C) moved++;
    cmd(8'h45); rd_row(v); if (v == 8'hC3) moved++;
    chk("R5 one row", moved, 1);
    cmd(8'hE0);
    wait_scan();
    chk("R5 second irq", irq, 1);
    exp_img[2] = 8'h3C; exp_img[5] = 8'hC3;
    check_image("R5 image");
    cmd(8'hE0);
    // R8: wrap and hold
    cmd(8'h56);
    rd_row(v); chk("R8 r6", v, exp_img[6]);
    rd_row(v); chk("R8 r7", v, exp_img[7]);
    rd_row(v); chk("R8 wrap", v, exp_img[0]);
    rd_row(v); chk("R8 r1", v, exp_img[1]);
    cmd(8'h43);
    rd_row(v); chk("R8 hold a", v, exp_img[3]);
    rd_row(v); chk("R8 hold b", v, exp_img[3]);
    // R11: ignored commands
    cmd(8'h00); cmd(8'h8F); cmd(8'h49);
    rd_row(v); chk("R11 ptr", v, exp_img[3]);
    // R9: clear without flags has no effect, with flag lowers irq and rewinds
    mtx[1] = 8'h77; exp_img[1] = 8'h77;
    wait_scan();
    chk("R9 setup irq", irq, 1);
    cmd(8'hC0);
    chk("R9 no flag", irq, 1);
    cmd(8'h20); cmd(8'h5F);
    chk("R11 irq kept", irq, 1);
    cmd(8'hC2);
    chk("R9 cf irq", irq, 0);
    rd_row(v); chk("R9 rewind", v, exp_img[0]);
    // R9 with bit 0
    mtx[6] = 8'h81; exp_img[6] = 8'h81;
    wait_scan();
    cmd(8'h45);
    cmd(8'hC1);
    chk("R9 ca irq", irq, 0);
    rd_row(v); chk("R9 ca rewind", v, exp_img[0]);
    // R10: acknowledge on the sampling cycle of a changed row
    mtx[0] = 8'h12; exp_img[0] = 8'h12;
    wait_scan();
    chk("R10 setup irq", irq, 1);
    mtx[4] = 8'hE7; exp_img[4] = 8'hE7;
    while (row_sel != 8'h08) @(negedge clk);
    while (row_sel != 8'h10) @(negedge clk);
    repeat (DWELL - 1) @(negedge clk);
    cmd_we = 1'b1; cmd_data = 8'hE0;
    @(negedge clk); cmd_we = 1'b0; cmd_data = '0;
    chk("R10 irq stays", irq, 1);
    check_image("R10 image");
    cmd(8'hE0);
    chk("R10 later ack", irq, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule